// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block is a real-time clock and calendar driven by a one-cycle 1 Hz strobe. It counts seconds, minutes, hours (24-hour form), day of week, date, month, year and century, every field in packed BCD. Month lengths are built in. Leap years are decided from the BCD year and century, so 2000 is a leap year and 2100 is not.

Two register sets are kept. The running set advances on every tick and is never stopped by the host. The host-visible set copies the running set on each clock edge until the host freezes it. A read freeze holds a coherent snapshot for reading. A write freeze lets the host compose a new time in the visible set. When the write freeze is released, that time is loaded into the running set on the next clock edge.

The host reaches the clock through a byte-wide port with active-low chip enable, output enable and write enable. The port sits in the sixteen highest locations of a 13-bit address space. Writes are sampled on the rising clock edge. Read data is combinational from the visible set, and `data_oe` stands for the drive enable of a tri-state bus.

Top module: `rtc_calendar_top`

## Requirements
- R1: After reset the time reads century 20, year 00, month 01, date 01, day-of-week 01, 00:00:00, and the control byte reads 0x00.
- R2: A tick advances the seconds in BCD. Seconds 59 become 00 and increment minutes. Minutes 59 become 00 and increment hours. Hours 23 become 00. Without a tick or a load, the running set holds its value.
- R3: Day-of-week advances with the date when hours roll from 23 to 00, and it goes from 7 back to 1.
- R4: Months 04, 06, 09 and 11 end on date 30. Month 02 ends on 28 or 29. All other months end on 31. The last date rolls to 01 and increments the month, and month 12 rolls to 01 and increments the year.
- R5: February has 29 days when the nonzero BCD year is divisible by 4, and when the year is 00 and the century is divisible by 4. Otherwise it has 28 days, so 2024 and 2000 are leap years while 2023 and 2100 are not.
- R6: Year 99 rolls to 00 and increments the century.
- R7: `data_oe` is 1 only when `ce_n`=0, `oe_n`=0, `we_n`=1 and the address lies in the clock window 0x1FF0 to 0x1FFF. In every other case the bus is not driven.
- R8: The window offsets are: 0 control (bit 0 read freeze, bit 1 write freeze), 1 seconds, 2 minutes, 3 hours, 4 day-of-week, 5 date, 6 month, 7 year, 8 century.
- R9: With both freeze bits clear, the visible set equals the running set as it stood one clock earlier.
- R10: While the read-freeze bit alone is set, the visible set does not change across ticks. The running set keeps counting, and its count is visible once the freeze is cleared.
- R11: While the write-freeze bit is set, writes to time offsets change only the visible set. Clearing the bit loads the visible set into the running set on the next clock edge. A tick on that edge is dropped.
- R12: Writes to time offsets while write freeze is clear have no effect. Offsets 9 to 15 ignore writes and read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 13 | Byte address |
| data_in | input | 8 | Write data |
| data_out | output | 8 | Read data, zero when not driving |
| data_oe | output | 1 | Bus drive enable |

## Verification
The following are checked on every cycle: the bus drive conditions, BCD range limits on the running seconds, minutes and hours, the range of the day-of-week, holding of the running set between ticks, mirroring while unfrozen, stability of the visible set under read freeze, and the transfer from the visible set to the running set on release. Only the bench scenarios can show the calendar outcomes: the end of February in 2024, 2023, 2000 and 2100, 30-day months, the century carry, and that writes outside write freeze or to spare offsets are ignored. The bench reads these results through the host port after chosen tick sequences.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned NUM_FIELDS = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] cent;
        logic [BYTE_W-1:0] year;
        logic [BYTE_W-1:0] month;
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] dow;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] sec;
    } rtc_time_t;

    // field index i sits at window offset i+1
    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DOW   = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6,
        FLD_CENT  = 3'd7
    } rtc_field_e;

    localparam rtc_time_t RTC_RESET_TIME = '{
        cent: 8'h20, year: 8'h00, month: 8'h01, date: 8'h01,
        dow: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00
    };

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
        return v + 8'h01;
    endfunction

    // packed BCD value divisible by four
    function automatic logic bcd_div4(input logic [7:0] v);
        logic tens_odd;
        logic [3:0] units;
        tens_odd = v[4];
        units    = v[3:0];
        if (!tens_odd) return (units == 4'h0) || (units == 4'h4) || (units == 4'h8);
        return (units == 4'h2) || (units == 4'h6);
    endfunction

    function automatic logic bcd_leap(input logic [7:0] year, input logic [7:0] cent);
        if (year == 8'h00) return bcd_div4(cent);
        return bcd_div4(year);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] month, input logic leap);
        case (month)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [7:0] field_get(input rtc_time_t t, input rtc_field_e f);
        case (f)
            FLD_SEC:   return t.sec;
            FLD_MIN:   return t.min;
            FLD_HOUR:  return t.hour;
            FLD_DOW:   return t.dow;
            FLD_DATE:  return t.date;
            FLD_MONTH: return t.month;
            FLD_YEAR:  return t.year;
            default:   return t.cent;
        endcase
    endfunction

endpackage

// File: rtl/rtc_calendar_step.sv
module rtc_calendar_step
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    output rtc_time_t nxt
);

    logic       leap;
    logic [7:0] last_date;

    always_comb begin
        leap      = bcd_leap(cur.year, cur.cent);
        last_date = month_last(cur.month, leap);
    end

    always_comb begin
        nxt = cur;
        if (cur.sec != 8'h59) begin
            nxt.sec = bcd_inc(cur.sec);
        end else begin
            nxt.sec = 8'h00;
            if (cur.min != 8'h59) begin
                nxt.min = bcd_inc(cur.min);
            end else begin
                nxt.min = 8'h00;
                if (cur.hour != 8'h23) begin
                    nxt.hour = bcd_inc(cur.hour);
                end else begin
                    nxt.hour = 8'h00;
                    nxt.dow  = (cur.dow >= 8'h07) ? 8'h01 : cur.dow + 8'h01;
                    if (cur.date != last_date) begin
                        nxt.date = bcd_inc(cur.date);
                    end else begin
                        nxt.date = 8'h01;
                        if (cur.month != 8'h12) begin
                            nxt.month = bcd_inc(cur.month);
                        end else begin
                            nxt.month = 8'h01;
                            if (cur.year != 8'h99) begin
                                nxt.year = bcd_inc(cur.year);
                            end else begin
                                nxt.year = 8'h00;
                                nxt.cent = (cur.cent == 8'h99) ? 8'h00 : bcd_inc(cur.cent);
                            end
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t cur
);

    rtc_time_t stepped;

    rtc_calendar_step u_step (
        .cur (cur),
        .nxt (stepped)
    );

    always_ff @(posedge clk) begin
        if (rst)       cur <= RTC_RESET_TIME;
        else if (load) cur <= load_val;
        else if (tick) cur <= stepped;
    end

endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
    import rtc_pkg::*;
#(
    parameter int unsigned ADDR_W       = 13,
    parameter int unsigned NUM_CLK_REGS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  rtc_time_t         core_time,
    output logic [BYTE_W-1:0] rdata,
    output logic              drive,
    output rtc_time_t         vis_time,
    output logic              rd_freeze,
    output logic              wr_freeze,
    output logic              load_req
);

    localparam int unsigned OFS_W = $clog2(NUM_CLK_REGS);
    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'((1 << ADDR_W) - NUM_CLK_REGS);

    logic              in_win;
    logic [OFS_W-1:0]  ofs;
    logic              wr_en;
    logic              frozen;
    logic [BYTE_W-1:0] vis_f [NUM_FIELDS];

    assign in_win = (addr >= WIN_BASE);
    assign ofs    = addr[OFS_W-1:0];
    assign wr_en  = !ce_n && !we_n && in_win;
    assign frozen = rd_freeze || wr_freeze;
    assign drive  = !ce_n && !oe_n && we_n && in_win;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_freeze <= 1'b0;
            wr_freeze <= 1'b0;
            load_req  <= 1'b0;
        end else if (wr_en && ofs == '0) begin
            rd_freeze <= wdata[0];
            wr_freeze <= wdata[1];
            load_req  <= wr_freeze && !wdata[1];
        end else begin
            load_req  <= 1'b0;
        end
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst)
                vis_f[g] <= field_get(RTC_RESET_TIME, rtc_field_e'(g));
            else if (wr_en && wr_freeze && ofs == OFS_W'(g + 1))
                vis_f[g] <= wdata;
            else if (!frozen && !load_req)
                vis_f[g] <= field_get(core_time, rtc_field_e'(g));
        end
    end

    always_comb begin
        vis_time.sec   = vis_f[FLD_SEC];
        vis_time.min   = vis_f[FLD_MIN];
        vis_time.hour  = vis_f[FLD_HOUR];
        vis_time.dow   = vis_f[FLD_DOW];
        vis_time.date  = vis_f[FLD_DATE];
        vis_time.month = vis_f[FLD_MONTH];
        vis_time.year  = vis_f[FLD_YEAR];
        vis_time.cent  = vis_f[FLD_CENT];
    end

    always_comb begin
        rdata = '0;
        if (ofs == '0) rdata = {{(BYTE_W-2){1'b0}}, wr_freeze, rd_freeze};
        for (int i = 0; i < NUM_FIELDS; i++)
            if (ofs == OFS_W'(i + 1)) rdata = vis_f[i];
    end

endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top
    import rtc_pkg::*;
#(
    parameter int unsigned ADDR_W       = 13,
    parameter int unsigned NUM_CLK_REGS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data_in,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe
);

    rtc_time_t         core_time;
    rtc_time_t         vis_time;
    logic [BYTE_W-1:0] rdata;
    logic              rd_freeze;
    logic              wr_freeze;
    logic              load_req;

    rtc_time_core u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1hz),
        .load     (load_req),
        .load_val (vis_time),
        .cur      (core_time)
    );

    rtc_host_port #(
        .ADDR_W       (ADDR_W),
        .NUM_CLK_REGS (NUM_CLK_REGS)
    ) u_port (
        .clk       (clk),
        .rst       (rst),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .addr      (addr),
        .wdata     (data_in),
        .core_time (core_time),
        .rdata     (rdata),
        .drive     (data_oe),
        .vis_time  (vis_time),
        .rd_freeze (rd_freeze),
        .wr_freeze (wr_freeze),
        .load_req  (load_req)
    );

    assign data_out = data_oe ? rdata : '0;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      tick_1hz,
    input logic      ce_n,
    input logic      oe_n,
    input logic      we_n,
    input logic      data_oe,
    input rtc_time_t core_time,
    input rtc_time_t vis_time,
    input logic      rd_freeze,
    input logic      wr_freeze,
    input logic      load_req
);

    // R7
    bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (!ce_n && !oe_n && we_n));

    // R2
    time_range_chk: assert property (@(posedge clk) disable iff (rst)
        (core_time.sec <= 8'h59) && (core_time.sec[3:0] <= 4'h9) &&
        (core_time.min <= 8'h59) && (core_time.min[3:0] <= 4'h9) &&
        (core_time.hour <= 8'h23) && (core_time.hour[3:0] <= 4'h9));

    // R3
    dow_range_chk: assert property (@(posedge clk) disable iff (rst)
        (core_time.dow >= 8'h01) && (core_time.dow <= 8'h07));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_1hz && !load_req) |=> $stable(core_time));

    // R9
    mirror_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_freeze && !wr_freeze && !load_req) |=> (vis_time == $past(core_time)));

    // R10
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_freeze && !wr_freeze) |=> $stable(vis_time));

    // R11
    load_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        load_req |=> (core_time == $past(vis_time)));

endmodule

bind rtc_calendar_top rtc_calendar_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_1hz  (tick_1hz),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .data_oe   (data_oe),
    .core_time (core_time),
    .vis_time  (vis_time),
    .rd_freeze (rd_freeze),
    .wr_freeze (wr_freeze),
    .load_req  (load_req)
);

// File: tb/tb_rtc_calendar_top.sv
module tb_rtc_calendar_top;
    import rtc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [12:0] BASE = 13'h1FF0;

    typedef struct {
        logic [7:0] exp;
        logic       exp_oe;
        string      tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;

    int        checks = 0;
    int        failures = 0;
    logic      rd_strobe = 1'b0;
    bit        done = 1'b0;
    exp_item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_calendar_top dut (
        .clk      (clk),
        .rst      (rst),
        .tick_1hz (tick_1hz),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .addr     (addr),
        .data_in  (data_in),
        .data_out (data_out),
        .data_oe  (data_oe)
    );

    // monitor: pops one expected item per read strobe
    always @(negedge clk) begin
        if (rd_strobe && sb.size() > 0) begin
            exp_item_t it;
            it = sb.pop_front();
            checks++;
            if (it.exp_oe) begin
                if (data_oe !== 1'b1 || data_out !== it.exp) begin
                    failures++;
                    $display("FAIL %s: oe=%b data=%h expected oe=1 data=%h",
                             it.tag, data_oe, data_out, it.exp);
                end
            end else if (data_oe !== 1'b0) begin
                failures++;
                $display("FAIL %s: oe=%b expected oe=0", it.tag, data_oe);
            end
        end
    end

    task automatic bus_read(input logic [12:0] a, input logic oe_val,
                            input logic [7:0] exp, input logic exp_oe, input string tag);
        exp_item_t it;
        @(posedge clk); #1;
        addr = a; ce_n = 1'b0; oe_n = oe_val; we_n = 1'b1;
        it.exp = exp; it.exp_oe = exp_oe; it.tag = tag;
        sb.push_back(it);
        rd_strobe = 1'b1;
        @(posedge clk); #1;
        rd_strobe = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd(input int ofs, input logic [7:0] exp, input string tag);
        bus_read(BASE + 13'(ofs), 1'b0, exp, 1'b1, tag);
    endtask

    task automatic wr(input int ofs, input logic [7:0] d);
        @(posedge clk); #1;
        addr = BASE + 13'(ofs); data_in = d; ce_n = 1'b0; we_n = 1'b0;
        @(posedge clk); #1;
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic tick();
        @(posedge clk); #1 tick_1hz = 1'b1;
        @(posedge clk); #1 tick_1hz = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    task automatic set_time(input rtc_time_t t);
        wr(0, 8'h02);
        wr(1, t.sec);  wr(2, t.min);  wr(3, t.hour); wr(4, t.dow);
        wr(5, t.date); wr(6, t.month); wr(7, t.year); wr(8, t.cent);
        wr(0, 8'h00);
        idle(3);
    endtask

    task automatic check_time(input rtc_time_t t, input string tag);
        rd(1, t.sec,   {tag, " sec"});
        rd(2, t.min,   {tag, " min"});
        rd(3, t.hour,  {tag, " hour"});
        rd(4, t.dow,   {tag, " dow"});
        rd(5, t.date,  {tag, " date"});
        rd(6, t.month, {tag, " month"});
        rd(7, t.year,  {tag, " year"});
        rd(8, t.cent,  {tag, " cent"});
    endtask

    function automatic rtc_time_t mk(input logic [7:0] c, y, mo, d, w, h, mi, s);
        rtc_time_t t;
        t.cent = c; t.year = y; t.month = mo; t.date = d;
        t.dow = w; t.hour = h; t.min = mi; t.sec = s;
        return t;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        #1 rst = 1'b0;
        idle(2);

        // R1 reset state
        check_time(mk(8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), "R1 reset");
        rd(0, 8'h00, "R1 control");
        // R12 spare offset reads zero
        rd(10, 8'h00, "R12 spare read");

        // R7 bus modes: outside window, oe_n high, write mode
        bus_read(13'h0000, 1'b0, 8'h00, 1'b0, "R7 outside window");
        bus_read(BASE + 13'd1, 1'b1, 8'h00, 1'b0, "R7 oe_n high");
        bus_read(13'h1FEF, 1'b0, 8'h00, 1'b0, "R7 below window");

        // R11 load via write freeze; R2/R3/R5 rollover into leap day 2024
        set_time(mk(8'h20, 8'h24, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58));
        rd(1, 8'h58, "R11 loaded sec");
        tick();
        idle(2);
        rd(1, 8'h59, "R2 sec step");
        tick();
        idle(2);
        check_time(mk(8'h20, 8'h24, 8'h02, 8'h29, 8'h01, 8'h00, 8'h00, 8'h00), "R5 R3 leap 2024");

        // R5 non-leap 2023
        set_time(mk(8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59));
        tick(); idle(2);
        check_time(mk(8'h20, 8'h23, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00), "R5 nonleap 2023");

        // R5 century years 2100 (not leap) and 2000 (leap)
        set_time(mk(8'h21, 8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59));
        tick(); idle(2);
        rd(5, 8'h01, "R5 2100 date"); rd(6, 8'h03, "R5 2100 month");
        set_time(mk(8'h20, 8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59));
        tick(); idle(2);
        rd(5, 8'h29, "R5 2000 date"); rd(6, 8'h02, "R5 2000 month");

        // R4 30-day month and 31-day month
        set_time(mk(8'h20, 8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59));
        tick(); idle(2);
        rd(5, 8'h01, "R4 april end date"); rd(6, 8'h05, "R4 april end month");
        set_time(mk(8'h20, 8'h24, 8'h05, 8'h30, 8'h04, 8'h23, 8'h59, 8'h59));
        tick(); idle(2);
        rd(5, 8'h31, "R4 may 31"); rd(6, 8'h05, "R4 may month");

        // R6 year and century carry; R3 dow wrap 7->1
        set_time(mk(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59));
        tick(); idle(2);
        check_time(mk(8'h21, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), "R6 century");

        // R12 writes without write freeze are ignored
        wr(1, 8'h33);
        wr(11, 8'h55);
        idle(2);
        rd(1, 8'h00, "R12 sec unchanged");
        rd(11, 8'h00, "R12 spare ignored");
        tick(); idle(2);
        rd(1, 8'h01, "R12 running sec unchanged by write");

        // R10 read freeze holds snapshot, running set keeps counting
        set_time(mk(8'h20, 8'h24, 8'h06, 8'h15, 8'h06, 8'h10, 8'h20, 8'h10));
        wr(0, 8'h01);
        rd(0, 8'h01, "R8 control read freeze bit");
        tick(); tick(); tick(); idle(2);
        rd(1, 8'h10, "R10 frozen sec");
        wr(0, 8'h00);
        idle(2);
        rd(1, 8'h13, "R10 R9 sec after release");

        // R11 write freeze: visible only, then load; tick while frozen dropped
        wr(0, 8'h02);
        wr(1, 8'h40);
        tick(); idle(2);
        rd(1, 8'h40, "R11 visible holds written sec");
        rd(0, 8'h02, "R8 control write freeze bit");
        wr(0, 8'h00);
        idle(2);
        rd(1, 8'h40, "R11 loaded on release");
        tick(); idle(2);
        rd(1, 8'h41, "R11 running from loaded value");
        rd(2, 8'h20, "R11 minutes kept");

        idle(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule